// File: doc/BRIEF.md
# Address Breakpoint Interrupt Unit

This block watches the instruction-fetch address of a CPU and asks for a break interrupt when that address equals a 16-bit breakpoint held in two byte-wide registers. A match is not acted on at once. It is recorded as pending, and the request is issued at the next instruction boundary, so the instruction in progress always completes. Software can also start a break directly by writing a control bit.

While the break is active, the unit holds the watchdog suspended. It also reports whether peripheral status flags may be cleared. Clearing is always allowed outside a break. Inside a break it is allowed only when a dedicated enable bit is set. The break ends when the CPU reports that it has completed a return-from-interrupt. The unit also presents the base address of the break vector pair. That base depends on a monitor-mode input.

Top module: `brk_unit`

## Requirements
- R1: After a synchronous reset, both address bytes and all control bits read 0. `brk_req`, `brk_active` and `cop_hold` are 0, `flag_clr_ok` is 1 and `vec_base` is 0xFFFC.
- R2: The register port is selected by `reg_sel`: 0 is the address high byte, 1 the address low byte and 2 the control register. The control register holds bit 7 = match enable, bit 6 = break active and bit 0 = flag-clear enable. A write takes effect when `reg_wr` is high at a clock edge. `reg_rdata` shows the selected register one cycle after `reg_sel` is applied.
- R3: A match is recorded as pending only when three conditions hold in the same cycle: `fetch_vld` is high, `fetch_addr` equals the breakpoint, and the match enable bit is 1. A non-fetch access to the same address is ignored, and so is any access while the enable bit is 0.
- R4: A pending break is released at the next cycle with `insn_end` high. In the cycle after that boundary, `brk_req` is 1 for exactly one cycle and `brk_active` becomes 1. A match seen in the same cycle as a boundary waits for the following boundary.
- R5: Writing the control register with bit 6 = 1 sets `brk_active` on the next cycle, whatever the match enable bit holds. It also queues a request that is issued at the next boundary. Writing bit 6 = 0 leaves `brk_active` unchanged.
- R6: While a break is active, an address match neither re-arms nor stacks a second request.
- R7: `rti_done` clears both the active state and any pending break on the next cycle. If it coincides with a software write of bit 6 = 1, the clear wins.
- R8: `cop_hold` equals `brk_active` in every cycle.
- R9: `flag_clr_ok` equals NOT `brk_active` OR the flag-clear enable bit, in every cycle.
- R10: `vec_base` is 0xFEFC one cycle after `monitor_mode` is 1, and 0xFFFC one cycle after it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| fetch_addr | input | 16 | CPU bus address |
| fetch_vld | input | 1 | Address is an instruction fetch |
| insn_end | input | 1 | Current instruction completes this cycle |
| rti_done | input | 1 | Return-from-interrupt completed |
| monitor_mode | input | 1 | Selects the monitor vector base |
| brk_req | output | 1 | One-cycle break request to the CPU |
| brk_active | output | 1 | Break state |
| cop_hold | output | 1 | Watchdog suspend |
| flag_clr_ok | output | 1 | Peripheral flag clearing permitted |
| vec_base | output | 16 | Break vector pair base address |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is an address match and the instruction boundary. The bench drives `fetch_vld` with the breakpoint address while `insn_end` is high. It judges that no request appears at that boundary and that a request does appear at the next one.

The second pair is a software write of the active bit and `rti_done`. The bench drives both in one cycle and expects `brk_active` to stay 0 afterwards.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_NONE    = 2'd3
  } brk_sel_e;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_ACT_BIT = 6;
  localparam int CTRL_FCE_BIT = 0;
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              active_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [AW-1:0]     brk_addr,
  output logic              match_en,
  output logic              fce_q,
  output logic              fce_nxt,
  output logic              sw_set
);
  import brk_pkg::*;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << CTRL_EN_BIT) | (1 << CTRL_ACT_BIT) | (1 << CTRL_FCE_BIT));

  logic ctrl_wr;
  logic en_nxt;
  logic [DATA_W-1:0] ctrl_rd;
  logic unused_wbits;

  assign ctrl_wr      = reg_wr && (brk_sel_e'(reg_sel) == SEL_CTRL);
  assign sw_set       = ctrl_wr && reg_wdata[CTRL_ACT_BIT];
  assign en_nxt       = ctrl_wr ? reg_wdata[CTRL_EN_BIT]  : match_en;
  assign fce_nxt      = ctrl_wr ? reg_wdata[CTRL_FCE_BIT] : fce_q;
  assign unused_wbits = ^(reg_wdata & ~CTRL_MASK);

  // one byte lane of the breakpoint per generate iteration
  for (genvar b = 0; b < 2; b++) begin : g_lane
    localparam brk_sel_e LANE_SEL = (b == 1) ? SEL_ADDR_HI : SEL_ADDR_LO;
    always_ff @(posedge clk) begin
      if (rst)
        brk_addr[b*DATA_W +: DATA_W] <= '0;
      else if (reg_wr && brk_sel_e'(reg_sel) == LANE_SEL)
        brk_addr[b*DATA_W +: DATA_W] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_en <= 1'b0;
      fce_q    <= 1'b0;
    end else begin
      match_en <= en_nxt;
      fce_q    <= fce_nxt;
    end
  end

  always_comb begin
    ctrl_rd               = '0;
    ctrl_rd[CTRL_EN_BIT]  = match_en;
    ctrl_rd[CTRL_ACT_BIT] = active_q;
    ctrl_rd[CTRL_FCE_BIT] = fce_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (brk_sel_e'(reg_sel))
        SEL_ADDR_HI: reg_rdata <= brk_addr[DATA_W +: DATA_W];
        SEL_ADDR_LO: reg_rdata <= brk_addr[0 +: DATA_W];
        SEL_CTRL:    reg_rdata <= ctrl_rd;
        default:     reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/brk_match.sv
module brk_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_vld,
  input  logic          match_en,
  input  logic [AW-1:0] brk_addr,
  output logic          hit
);
  assign hit = fetch_vld && match_en && (fetch_addr == brk_addr);
endmodule

// File: rtl/brk_core.sv
module brk_core #(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [AW-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          sw_set,
  input  logic          insn_end,
  input  logic          rti_done,
  input  logic          fce_nxt,
  input  logic          monitor_mode,
  output logic          active_q,
  output logic          brk_req,
  output logic          cop_hold,
  output logic          flag_clr_ok,
  output logic [AW-1:0] vec_base
);
  logic pend_q, pend_d, active_d, req_d, release_now;

  assign release_now = pend_q && insn_end;

  always_comb begin
    active_d = active_q;
    if (rti_done) active_d = 1'b0;
    else if (sw_set || release_now) active_d = 1'b1;

    pend_d = pend_q;
    if (rti_done || release_now) pend_d = 1'b0;
    else if (sw_set || (hit && !active_q)) pend_d = 1'b1;

    req_d = release_now && !rti_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      active_q    <= 1'b0;
      brk_req     <= 1'b0;
      cop_hold    <= 1'b0;
      flag_clr_ok <= 1'b1;
      vec_base    <= VEC_NORM;
    end else begin
      pend_q      <= pend_d;
      active_q    <= active_d;
      brk_req     <= req_d;
      cop_hold    <= active_d;
      flag_clr_ok <= !active_d || fce_nxt;
      vec_base    <= monitor_mode ? VEC_MON : VEC_NORM;
    end
  end
endmodule

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W,
  parameter logic [AW-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [AW-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              fetch_vld,
  input  logic              insn_end,
  input  logic              rti_done,
  input  logic              monitor_mode,
  output logic              brk_req,
  output logic              brk_active,
  output logic              cop_hold,
  output logic              flag_clr_ok,
  output logic [AW-1:0]     vec_base
);
  logic [AW-1:0] brk_addr;
  logic match_en, ctl_fce, fce_nxt, sw_set, hit;

  brk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .active_q(brk_active), .reg_rdata(reg_rdata),
    .brk_addr(brk_addr), .match_en(match_en), .fce_q(ctl_fce),
    .fce_nxt(fce_nxt), .sw_set(sw_set)
  );

  brk_match #(.AW(AW)) u_match (
    .fetch_addr(fetch_addr), .fetch_vld(fetch_vld), .match_en(match_en),
    .brk_addr(brk_addr), .hit(hit)
  );

  brk_core #(.AW(AW), .VEC_NORM(VEC_NORM), .VEC_MON(VEC_MON)) u_core (
    .clk(clk), .rst(rst), .hit(hit), .sw_set(sw_set), .insn_end(insn_end),
    .rti_done(rti_done), .fce_nxt(fce_nxt), .monitor_mode(monitor_mode),
    .active_q(brk_active), .brk_req(brk_req), .cop_hold(cop_hold),
    .flag_clr_ok(flag_clr_ok), .vec_base(vec_base)
  );
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [AW-1:0] VEC_MON  = 16'hFEFC
) (
  input logic          clk,
  input logic          rst,
  input logic          insn_end,
  input logic          rti_done,
  input logic          monitor_mode,
  input logic          brk_req,
  input logic          brk_active,
  input logic          cop_hold,
  input logic          flag_clr_ok,
  input logic          fce,
  input logic [AW-1:0] vec_base
);
  a_r4_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> !brk_req);
  a_r4_req_at_boundary: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(insn_end));
  a_r4_req_with_active: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> brk_active);
  a_r7_rti_clears: assert property (@(posedge clk) disable iff (rst)
    rti_done |=> (!brk_active && !brk_req));
  a_r8_cop_tracks: assert property (@(posedge clk) disable iff (rst)
    cop_hold == brk_active);
  a_r9_flag_permit: assert property (@(posedge clk) disable iff (rst)
    flag_clr_ok == (!brk_active || fce));
  a_r10_vector: assert property (@(posedge clk) disable iff (rst)
    monitor_mode |=> vec_base == VEC_MON);
  a_r10_vector_norm: assert property (@(posedge clk) disable iff (rst)
    !monitor_mode |=> vec_base == VEC_NORM);
endmodule

bind brk_unit brk_unit_chk #(.AW(AW), .VEC_NORM(VEC_NORM), .VEC_MON(VEC_MON)) u_chk (
  .clk(clk), .rst(rst), .insn_end(insn_end), .rti_done(rti_done),
  .monitor_mode(monitor_mode), .brk_req(brk_req), .brk_active(brk_active),
  .cop_hold(cop_hold), .flag_clr_ok(flag_clr_ok), .fce(ctl_fce),
  .vec_base(vec_base)
);

// File: tb/brk_unit_test.sv
module brk_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] reg_sel = 2'd3;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [15:0] fetch_addr = 16'h0000;
  logic fetch_vld = 1'b0, insn_end = 1'b0, rti_done = 1'b0, monitor_mode = 1'b0;
  logic brk_req, brk_active, cop_hold, flag_clr_ok;
  logic [15:0] vec_base;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  brk_unit uut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
    .fetch_vld(fetch_vld), .insn_end(insn_end), .rti_done(rti_done),
    .monitor_mode(monitor_mode), .brk_req(brk_req), .brk_active(brk_active),
    .cop_hold(cop_hold), .flag_clr_ok(flag_clr_ok), .vec_base(vec_base)
  );

  // {fetch_addr, fetch_vld, insn_end, rti_done, exp_req, exp_active}
  localparam logic [20:0] VEC [13] = '{
    {16'h1234, 5'b000_00},  // R3 non-fetch ignored
    {16'h1234, 5'b010_00},
    {16'h1234, 5'b100_00},  // R3 match -> pending
    {16'h0000, 5'b010_11},  // R4 released at boundary
    {16'h0000, 5'b000_01},  // R4 single pulse
    {16'h1234, 5'b100_01},  // R6 no re-arm while active
    {16'h0000, 5'b010_01},  // R6
    {16'h0000, 5'b001_00},  // R7 rti ends break
    {16'h1235, 5'b100_00},  // R3 other address
    {16'h0000, 5'b010_00},
    {16'h1234, 5'b110_00},  // R4 match on boundary waits
    {16'h0000, 5'b010_11},  // R4 next boundary
    {16'h0000, 5'b001_00}   // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [7:0] exp, input string req);
    reg_sel = sel;
    step();
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 req", 32'(brk_req), 0);
    chk("R1 active", 32'(brk_active), 0);
    chk("R1 cop", 32'(cop_hold), 0);
    chk("R1 flag", 32'(flag_clr_ok), 1);
    chk("R1 vec", 32'(vec_base), 32'hFFFC);
    rd(2'd2, 8'h00, "R1 ctrl");
    rd(2'd0, 8'h00, "R1 addr hi");

    // R2 register access
    wr(2'd0, 8'h12);
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h80);
    rd(2'd0, 8'h12, "R2 hi");
    rd(2'd1, 8'h34, "R2 lo");
    rd(2'd2, 8'h80, "R2 ctrl");

    // vector table walk
    for (int i = 0; i < 13; i++) begin
      fetch_addr = VEC[i][20:5];
      fetch_vld  = VEC[i][4];
      insn_end   = VEC[i][3];
      rti_done   = VEC[i][2];
      step();
      chk($sformatf("R4 vec%0d req", i), 32'(brk_req), 32'(VEC[i][1]));
      chk($sformatf("R4 vec%0d active", i), 32'(brk_active), 32'(VEC[i][0]));
      chk($sformatf("R8 vec%0d cop", i), 32'(cop_hold), 32'(VEC[i][0]));
    end
    fetch_vld = 0; insn_end = 0; rti_done = 0;

    // R3 enable off: match ignored
    wr(2'd2, 8'h00);
    fetch_addr = 16'h1234; fetch_vld = 1; step();
    fetch_vld = 0; insn_end = 1; step();
    chk("R3 disabled req", 32'(brk_req), 0);
    chk("R3 disabled active", 32'(brk_active), 0);
    insn_end = 0;

    // R5 software start with enable off
    wr(2'd2, 8'h40);
    chk("R5 sw active", 32'(brk_active), 1);
    chk("R9 flag gated", 32'(flag_clr_ok), 0);
    rd(2'd2, 8'h40, "R5 ctrl readback");
    insn_end = 1; step(); insn_end = 0;
    chk("R5 sw req", 32'(brk_req), 1);
    step();
    chk("R5 pulse ends", 32'(brk_req), 0);

    // R5 write 0 to bit 6 keeps active; R9 fce permits clearing
    wr(2'd2, 8'h01);
    chk("R5 write0 no effect", 32'(brk_active), 1);
    chk("R9 flag fce", 32'(flag_clr_ok), 1);
    wr(2'd2, 8'h00);
    chk("R9 flag gated again", 32'(flag_clr_ok), 0);

    // R7 rti ends
    rti_done = 1; step(); rti_done = 0;
    chk("R7 cleared", 32'(brk_active), 0);
    chk("R9 flag idle", 32'(flag_clr_ok), 1);

    // R7 rti and software set collide: clear wins
    rti_done = 1; wr(2'd2, 8'h40); rti_done = 0;
    chk("R7 collision active", 32'(brk_active), 0);
    insn_end = 1; step(); insn_end = 0;
    chk("R7 collision no req", 32'(brk_req), 0);

    // R10 vector base
    monitor_mode = 1; step();
    chk("R10 monitor vec", 32'(vec_base), 32'hFEFC);
    monitor_mode = 0; step();
    chk("R10 normal vec", 32'(vec_base), 32'hFFFC);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule